// File: doc/BRIEF.md
# Unsigned Integer to Floating-Point Converter

This block turns an unsigned binary integer into a binary floating-point word in a format chosen at elaboration. The integer width and the output format (total width N, exponent width M) are parameters. The significand holds N-M bits, counting the hidden leading one. The conversion finds the most significant set bit, shifts the value so that bit lands at the top, forms the biased exponent and rounds away the bits that do not fit. Rounding follows one of five IEEE-style modes.

The rounding mode comes from a five-bit one-hot code on `rmIn`, or it is fixed by a parameter. When it is fixed, the input pin has no effect. The block has no registers. A system instantiates it wherever an integer result has to enter a floating-point datapath, and registers around it as its timing needs. The sign bit of the result is always zero. Zero maps to positive zero, and values too large for the format saturate according to the rounding direction.

Top module: `u2f_convert`

## Requirements
- R1: An input of zero yields an output word with every bit zero.
- R2: For a nonzero input v with leading one at bit p, the sign bit is 0 and the exponent field is p + B, where B = 2^(M-1)-1. The field is p + B + 1 when rounding carries out of the significand.
- R3: The fraction field holds the N-M-1 bits below the leading one, left aligned. An input whose significant bits all fit is converted exactly in every mode.
- R4: Mode code 5'b00001 rounds to nearest. On an exact tie it picks the result with an even last fraction bit.
- R5: Mode code 5'b00010 rounds to nearest. On an exact tie it moves away from zero.
- R6: Mode code 5'b00100 (toward +infinity) rounds up whenever any discarded bit is set.
- R7: Mode codes 5'b01000 (toward -infinity) and 5'b10000 (toward zero) both drop the discarded bits with no increment.
- R8: A mode code that does not have exactly one bit set is treated as 5'b00001.
- R9: When rounding overflows the significand, the fraction field becomes zero and the exponent rises by one.
- R10: When the exponent would reach the all-ones field, modes 5'b00001, 5'b00010 and 5'b00100 give infinity: all-ones exponent and zero fraction. Modes 5'b01000 and 5'b10000 give the largest finite value: exponent all ones minus one and an all-ones fraction.
- R11: With parameter FIXED_RM set to a nonzero one-hot code, that mode is used and `rmIn` has no effect on the output.
- R12: The output is a combinational function of the present inputs and is valid in the same cycle they are applied.

Formats outside 2 <= M <= N-2, or a nonzero FIXED_RM that is not one-hot, are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| intIn | input | IN_W | Unsigned integer to convert |
| rmIn | input | 5 | One-hot rounding mode code; unused when FIXED_RM is nonzero |
| fpOut | output | OUT_W | Packed result: sign, exponent, fraction |

## Verification
The bench builds three instances. Two use a 10-bit input and a 9-bit output with a 4-bit exponent (bias 7, 4 fraction bits). One of these takes its mode from the pin and the other is fixed to round toward zero. In this small format, exponent overflow, carry out of the significand and ties in every mode can all be reached with inputs below 1024, and the two instances can be compared under the same stimulus. The third instance uses the default 32-bit input and 32/8 format. It covers exact conversion up to 24 significant bits, ties just above 2^24, and the carry at the all-ones input.

// File: rtl/u2f_pkg.sv
package u2f_pkg;

  localparam logic [4:0] RM_EVEN = 5'b00001;
  localparam logic [4:0] RM_AWAY = 5'b00010;
  localparam logic [4:0] RM_UP   = 5'b00100;
  localparam logic [4:0] RM_DOWN = 5'b01000;
  localparam logic [4:0] RM_ZERO = 5'b10000;

  // strobes from rounding control to the packing datapath
  typedef struct packed {
    logic bumpUp;   // add one unit in the last place
    logic satMax;   // overflow saturates to largest finite value
  } rndCtl_t;

endpackage

// File: rtl/u2f_normalize.sv
module u2f_normalize #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned SIG_W = 24,
  parameter int unsigned POS_W = 5
) (
  input  logic [IN_W-1:0]  intIn,
  output logic             isZero,
  output logic [POS_W-1:0] leadPos,
  output logic [SIG_W-1:0] sig,
  output logic             guardBit,
  output logic             stickyBit
);

  localparam int unsigned EXT_W = IN_W + SIG_W + 1;

  logic [POS_W-1:0] shAmt;
  logic [IN_W-1:0]  stg [0:POS_W];
  logic [IN_W-1:0]  normVal;
  logic [EXT_W-1:0] extVal;

  // leading-one detector: highest set bit wins
  always_comb begin
    leadPos = '0;
    for (int i = 0; i < int'(IN_W); i++) begin
      if (intIn[i]) leadPos = POS_W'(i);
    end
  end

  assign isZero = (intIn == '0);
  assign shAmt  = POS_W'(IN_W - 1) - leadPos;

  // logarithmic left shifter, one stage per shift-amount bit
  assign stg[0] = intIn;
  for (genvar k = 0; k < int'(POS_W); k++) begin : g_shift
    assign stg[k+1] = shAmt[k] ? (stg[k] << (2 ** k)) : stg[k];
  end
  assign normVal = stg[POS_W];

  // pad below so narrow inputs still fill the significand
  assign extVal    = {normVal, {(SIG_W + 1){1'b0}}};
  assign sig       = extVal[EXT_W-1 -: SIG_W];
  assign guardBit  = extVal[EXT_W-1-SIG_W];
  assign stickyBit = |extVal[EXT_W-2-SIG_W:0];

  // detector and shifter must agree: leading one lands on top
  always_comb begin
    if (!isZero) begin
      p_lead_one_r2: assert (normVal[IN_W-1])
        else $error("normalised value lost its leading one");
    end
  end

endmodule

// File: rtl/u2f_round_ctrl.sv
module u2f_round_ctrl
  import u2f_pkg::*;
#(
  parameter logic [4:0] FIXED_RM = 5'b00000
) (
  input  logic [4:0] rmIn,
  input  logic       lsbBit,
  input  logic       guardBit,
  input  logic       stickyBit,
  output rndCtl_t    ctl
);

  logic [4:0] modeSel;
  logic [4:0] modeEff;
  logic       modeOk;

  if (FIXED_RM != 5'b00000) begin : g_fixed
    if ((FIXED_RM & (FIXED_RM - 5'd1)) != 5'b00000) begin : g_badRm
      $error("FIXED_RM must be zero or one-hot");
    end
    logic unusedRm;
    assign unusedRm = ^rmIn;
    assign modeSel  = FIXED_RM;
  end else begin : g_dyn
    assign modeSel = rmIn;
  end

  assign modeOk  = (modeSel != 5'b00000) && ((modeSel & (modeSel - 5'd1)) == 5'b00000);
  assign modeEff = modeOk ? modeSel : RM_EVEN;

  always_comb begin
    ctl.bumpUp = 1'b0;
    ctl.satMax = 1'b0;
    case (modeEff)
      RM_EVEN: ctl.bumpUp = guardBit & (stickyBit | lsbBit);
      RM_AWAY: ctl.bumpUp = guardBit;
      RM_UP:   ctl.bumpUp = guardBit | stickyBit;
      RM_DOWN: ctl.satMax = 1'b1;
      RM_ZERO: ctl.satMax = 1'b1;
      default: ctl.bumpUp = 1'b0;
    endcase
  end

  always_comb begin
    p_mode_onehot_r8: assert ((modeEff != 5'b00000) && ((modeEff & (modeEff - 5'd1)) == 5'b00000))
      else $error("effective rounding mode not one-hot");
  end

endmodule

// File: rtl/u2f_pack.sv
module u2f_pack
  import u2f_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned POS_W  = 5
) (
  input  logic                    isZero,
  input  logic [POS_W-1:0]        leadPos,
  input  logic [FRAC_W:0]         sig,
  input  logic                    guardBit,
  input  logic                    stickyBit,
  input  rndCtl_t                 ctl,
  output logic [EXP_W+FRAC_W:0]   word
);

  localparam int unsigned SIG_W = FRAC_W + 1;
  localparam int unsigned XW    = ((EXP_W > POS_W) ? EXP_W : POS_W) + 2;
  localparam int unsigned BIAS  = (2 ** (EXP_W - 1)) - 1;
  localparam logic [XW-1:0] EXP_INF = XW'((2 ** EXP_W) - 1);
  localparam logic [EXP_W-1:0] EXP_MAXF = EXP_INF[EXP_W-1:0] - EXP_W'(1);

  logic [SIG_W:0]     sum;
  logic               carry;
  logic [XW-1:0]      biased;
  logic               ovf;
  logic [EXP_W-1:0]   expField;
  logic [FRAC_W-1:0]  fracField;

  assign sum    = {1'b0, sig} + (SIG_W + 1)'(ctl.bumpUp);
  assign carry  = sum[SIG_W];
  assign biased = XW'(leadPos) + XW'(carry) + XW'(BIAS);
  assign ovf    = (biased >= EXP_INF);

  always_comb begin
    if (isZero) begin
      expField  = '0;
      fracField = '0;
    end else if (ovf) begin
      expField  = ctl.satMax ? EXP_MAXF : EXP_INF[EXP_W-1:0];
      fracField = ctl.satMax ? '1 : '0;
    end else begin
      expField  = biased[EXP_W-1:0];
      fracField = sum[FRAC_W-1:0];
    end
  end

  assign word = {1'b0, expField, fracField};

  always_comb begin
    if (ctl.bumpUp) begin
      p_bump_inexact_r6: assert (guardBit | stickyBit)
        else $error("round-up requested on an exact value");
    end
    if (!isZero) begin
      p_nonzero_exp_r2: assert (word[EXP_W+FRAC_W-1 -: EXP_W] != '0)
        else $error("nonzero input produced a zero exponent");
      p_hidden_set_r3: assert (sig[FRAC_W])
        else $error("significand arrived without hidden bit");
    end
  end

endmodule

// File: rtl/u2f_convert.sv
module u2f_convert
  import u2f_pkg::*;
#(
  parameter int unsigned IN_W     = 32,
  parameter int unsigned OUT_W    = 32,
  parameter int unsigned EXP_W    = 8,
  parameter logic [4:0]  FIXED_RM = 5'b00000
) (
  input  logic [IN_W-1:0]  intIn,
  input  logic [4:0]       rmIn,
  output logic [OUT_W-1:0] fpOut
);

  localparam int unsigned FRAC_W = OUT_W - EXP_W - 1;
  localparam int unsigned SIG_W  = FRAC_W + 1;
  localparam int unsigned POS_W  = (IN_W > 1) ? $clog2(IN_W) : 1;

  if (EXP_W < 2 || EXP_W + 2 > OUT_W || IN_W < 1) begin : g_badCfg
    $error("unsupported format: need 2 <= EXP_W <= OUT_W-2 and IN_W >= 1");
  end

  logic             isZero;
  logic [POS_W-1:0] leadPos;
  logic [SIG_W-1:0] sig;
  logic             guardBit;
  logic             stickyBit;
  rndCtl_t          ctl;

  u2f_normalize #(
    .IN_W (IN_W),
    .SIG_W(SIG_W),
    .POS_W(POS_W)
  ) uNorm (
    .intIn    (intIn),
    .isZero   (isZero),
    .leadPos  (leadPos),
    .sig      (sig),
    .guardBit (guardBit),
    .stickyBit(stickyBit)
  );

  u2f_round_ctrl #(
    .FIXED_RM(FIXED_RM)
  ) uCtl (
    .rmIn     (rmIn),
    .lsbBit   (sig[0]),
    .guardBit (guardBit),
    .stickyBit(stickyBit),
    .ctl      (ctl)
  );

  u2f_pack #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W),
    .POS_W (POS_W)
  ) uPack (
    .isZero   (isZero),
    .leadPos  (leadPos),
    .sig      (sig),
    .guardBit (guardBit),
    .stickyBit(stickyBit),
    .ctl      (ctl),
    .word     (fpOut)
  );

endmodule

// File: tb/tb_u2f_convert.sv
`timescale 1ns/1ps
module tb_u2f_convert;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [9:0]  vIn  = '0;
  logic [31:0] wIn  = '0;
  logic [4:0]  rmIn = 5'b00001;
  logic [8:0]  outA;
  logic [8:0]  outF;
  logic [31:0] outW;

  u2f_convert #(.IN_W(10), .OUT_W(9), .EXP_W(4), .FIXED_RM(5'b00000)) dut (
    .intIn(vIn), .rmIn(rmIn), .fpOut(outA));
  u2f_convert #(.IN_W(10), .OUT_W(9), .EXP_W(4), .FIXED_RM(5'b10000)) dutFix (
    .intIn(vIn), .rmIn(rmIn), .fpOut(outF));
  u2f_convert dutWide (
    .intIn(wIn), .rmIn(rmIn), .fpOut(outW));

  typedef struct {
    string       req;
    logic [9:0]  v;
    logic [31:0] w;
    logic [4:0]  m;
    logic [8:0]  eA;
    logic [8:0]  eF;
    logic [31:0] eW;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // independent model: integer quotient/remainder rounding
  function automatic longint unsigned refConv(longint unsigned v, logic [4:0] mIn,
                                              int expW, int fracW);
    logic [4:0] m;
    int p, e, sh, bias;
    longint unsigned mant, rem, half, emax;
    bit up;
    m = ($countones(mIn) == 1) ? mIn : 5'b00001;
    if (v == 0) return 0;
    p = 0;
    for (int i = 0; i < 64; i++) if (v[i]) p = i;
    up = 1'b0;
    if (p <= fracW) begin
      mant = v << (fracW - p);
    end else begin
      sh   = p - fracW;
      mant = v >> sh;
      rem  = v & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      case (m)
        5'b00001: up = (rem > half) || ((rem == half) && mant[0]);
        5'b00010: up = (rem >= half);
        5'b00100: up = (rem != 0);
        default:  up = 1'b0;
      endcase
    end
    mant = mant + longint'(up);
    e = p;
    if (mant == (64'd1 << (fracW + 1))) begin
      mant = mant >> 1;
      e = e + 1;
    end
    bias = (1 << (expW - 1)) - 1;
    emax = (64'd1 << expW) - 1;
    if (longint'(e + bias) >= emax) begin
      if (m == 5'b01000 || m == 5'b10000)
        return ((emax - 1) << fracW) | ((64'd1 << fracW) - 1);
      return emax << fracW;
    end
    return (longint'(e + bias) << fracW) | (mant & ((64'd1 << fracW) - 1));
  endfunction

  task automatic drive(input logic [9:0] v, input logic [31:0] w,
                       input logic [4:0] m, input string req);
    item_t it;
    @(posedge clk);
    #1;
    vIn  = v;
    wIn  = w;
    rmIn = m;
    it.req = req;
    it.v = v;
    it.w = w;
    it.m = m;
    it.eA = 9'(refConv(64'(v), m, 4, 4));
    it.eF = 9'(refConv(64'(v), 5'b10000, 4, 4));
    it.eW = 32'(refConv(64'(w), m, 8, 23));
    q.push_back(it);
  endtask

  // monitor: outputs sampled half a cycle after the inputs change (R12)
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (outA !== it.eA) begin
        failures++;
        $display("FAIL %s dut v=%0d rm=%b got=%h exp=%h", it.req, it.v, it.m, outA, it.eA);
      end
      checks++;
      if (outF !== it.eF) begin  // R11: fixed instance ignores rmIn
        failures++;
        $display("FAIL R11 dutFix v=%0d rm=%b got=%h exp=%h", it.v, it.m, outF, it.eF);
      end
      checks++;
      if (outW !== it.eW) begin
        failures++;
        $display("FAIL %s dutWide w=%h rm=%b got=%h exp=%h", it.req, it.w, it.m, outW, it.eW);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog got=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [4:0] modes [5];
    modes[0] = 5'b00001; modes[1] = 5'b00010; modes[2] = 5'b00100;
    modes[3] = 5'b01000; modes[4] = 5'b10000;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(10'd0,  32'h0,         5'b00001, "R1");
    drive(10'd0,  32'h0,         5'b10000, "R1");
    drive(10'd1,  32'h1,         5'b00001, "R2");
    drive(10'd19, 32'h00AB_CDEF, 5'b00100, "R3");
    drive(10'd38, 32'h0080_0001, 5'b10000, "R3");
    drive(10'd37, 32'h0100_0001, 5'b00001, "R4");
    drive(10'd39, 32'h0100_0003, 5'b00001, "R4");
    drive(10'd37, 32'h0100_0001, 5'b00010, "R5");
    drive(10'd36, 32'h0100_0002, 5'b00010, "R5");
    drive(10'd33, 32'h0100_0001, 5'b00100, "R6");
    drive(10'd39, 32'h0100_0003, 5'b01000, "R7");
    drive(10'd39, 32'hFFFF_FFFF, 5'b10000, "R7");
    drive(10'd39, 32'h0100_0003, 5'b00000, "R8");
    drive(10'd37, 32'h0100_0001, 5'b00110, "R8");
    drive(10'd63, 32'hFFFF_FFFF, 5'b00001, "R9");
    drive(10'd63, 32'h01FF_FFFF, 5'b00100, "R9");
    drive(10'd255,  32'h7FFF_FFFF, 5'b00001, "R10");
    drive(10'd255,  32'h7FFF_FFFF, 5'b00100, "R10");
    drive(10'd255,  32'h7FFF_FFFF, 5'b01000, "R10");
    drive(10'd1023, 32'h8000_0000, 5'b10000, "R10");
    drive(10'd1023, 32'h8000_0000, 5'b00010, "R10");
    drive(10'd200,  32'h1234_5678, 5'b00001, "R11");
    drive(10'd200,  32'h1234_5678, 5'b00100, "R11");
    for (int k = 0; k < 1024; k += 7) begin
      drive(10'(k), 32'(k * 32'd2654435761), modes[k % 5], "R12");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule